// File: doc/BRIEF.md
# Ternary Routing Lookup

This block resolves a destination address to an output port for a packet router. It holds a small table of rows. Each row carries a ternary pattern over the address bits, an output-port value and a valid bit. An address presented at the input is compared against every row in parallel. If several rows match, the lowest-numbered matching row wins. Its port value is read out. If no row matches, a no-match flag is raised instead.

The lookup is an overlapped three-stage pipeline: address latch, pattern compare, then priority select with the port-table read. A new address may enter every cycle. A program port selects one row by index and writes the pattern, the port value and the valid bit to that row in a single cycle. A pattern that contains the illegal digit code is refused. A write has priority over a lookup presented in the same cycle. That lookup is held off for the cycle, and the source keeps it on the input until it is taken.

Top module: `route_lookup`

## Requirements
- R1: Each address digit i is stored as bits {2i+1, 2i} of the pattern. Code 00 accepts either address bit, 01 accepts only a 1, and 10 accepts only a 0. A row matches when every digit accepts its address bit.
- R2: A write whose pattern holds code 11 in any digit leaves the row untouched, including its valid bit. `progError` is high in the cycle after that write and low in every other cycle.
- R3: When more than one valid row matches, the port value of the matching row with the lowest index is returned.
- R4: When no valid row matches, the result shows `resultNoMatch` = 1 and `resultPort` = 0.
- R5: After reset every row is invalid, and a row written with `progRowValid` = 0 never matches.
- R6: An address accepted at a rising edge produces its result on the outputs after the second following rising edge, which is the third edge counted from the accepting one. Back-to-back addresses give back-to-back results.
- R7: `lookupStall` is high exactly while `progWrite` is high. A lookup offered in such a cycle is not accepted and produces no result.
- R8: A legal write stores the pattern, the port value and the valid bit at row `progRow` at one edge. A lookup accepted at that edge or later compares against the new pattern.
- R9: Whenever `resultValid` is low, `resultPort` and `resultNoMatch` are both 0.
- R10: After reset, `resultValid`, `resultPort`, `resultNoMatch` and `progError` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | An address is offered |
| lookupAddr | input | ADDR_W | Destination address to resolve |
| lookupStall | output | 1 | Offered address not taken this cycle |
| progWrite | input | 1 | Write one table row |
| progRow | input | $clog2(ROWS) | Row index to write |
| progPattern | input | 2*ADDR_W | Ternary pattern, two bits per digit |
| progPort | input | PORT_W | Output-port value for the row |
| progRowValid | input | 1 | Valid bit written to the row |
| progError | output | 1 | Previous write was refused |
| resultValid | output | 1 | Result of a lookup is present |
| resultPort | output | PORT_W | Selected output port |
| resultNoMatch | output | 1 | No valid row matched |

## Verification
The bench builds the block with its defaults: 16 rows, a 3-bit address and a 2-bit port. With only eight addresses, random lookups reach every address many times. Random patterns over 16 rows overlap often, so lowest-index priority is decided among several hits in most lookups. Random writes landing between a lookup's compare stage and its port read show that the pattern and the port value are sampled at different edges.

// File: rtl/route_lookup_pkg.sv
package route_lookup_pkg;

  // Strobes from the control unit to the datapath, one per pipeline action.
  typedef struct packed {
    logic latchEn;   // capture the offered address
    logic cmpEn;     // stage 1 holds an address to compare
    logic selEn;     // stage 2 holds a match vector to resolve
    logic writeEn;   // legal table write this cycle
  } ctrlStrobes_t;

endpackage

// File: rtl/route_lookup_ctrl.sv
module route_lookup_ctrl
  import route_lookup_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int PAT_W = 2 * ADDR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lookupValid,
  input  logic             progWrite,
  input  logic [PAT_W-1:0] progPattern,
  output ctrlStrobes_t     strobes,
  output logic             lookupStall,
  output logic             resultValid,
  output logic             progError
);

  logic patIllegal;
  logic stage1Valid;
  logic stage2Valid;
  logic stage3Valid;

  // A digit coded 11 would demand both a one and a zero.
  always_comb begin
    patIllegal = 1'b0;
    for (int d = 0; d < ADDR_W; d++) begin
      if (progPattern[2*d +: 2] == 2'b11) patIllegal = 1'b1;
    end
  end

  // A write takes the cycle; an offered address waits.
  assign lookupStall     = progWrite;
  assign strobes.latchEn = lookupValid && !progWrite;
  assign strobes.cmpEn   = stage1Valid;
  assign strobes.selEn   = stage2Valid;
  assign strobes.writeEn = progWrite && !patIllegal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1Valid <= 1'b0;
      stage2Valid <= 1'b0;
      stage3Valid <= 1'b0;
      progError   <= 1'b0;
    end else begin
      stage1Valid <= strobes.latchEn;
      stage2Valid <= stage1Valid;
      stage3Valid <= stage2Valid;
      progError   <= progWrite && patIllegal;
    end
  end

  assign resultValid = stage3Valid;

endmodule

// File: rtl/route_lookup_prio.sv
module route_lookup_prio #(
  parameter int ROWS = 16,
  localparam int IDX_W = $clog2(ROWS)
) (
  input  logic [ROWS-1:0]  hits,
  output logic             anyHit,
  output logic [IDX_W-1:0] hitIdx
);

  // Scan from the bottom of the priority order so the lowest index wins.
  always_comb begin
    hitIdx = '0;
    for (int r = ROWS - 1; r >= 0; r--) begin
      if (hits[r]) hitIdx = IDX_W'(r);
    end
  end

  assign anyHit = |hits;

endmodule

// File: rtl/route_lookup_datapath.sv
module route_lookup_datapath
  import route_lookup_pkg::*;
#(
  parameter int ROWS   = 16,
  parameter int ADDR_W = 3,
  parameter int PORT_W = 2,
  localparam int IDX_W = $clog2(ROWS),
  localparam int PAT_W = 2 * ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] lookupAddr,
  input  logic [IDX_W-1:0]  progRow,
  input  logic [PAT_W-1:0]  progPattern,
  input  logic [PORT_W-1:0] progPort,
  input  logic              progRowValid,
  output logic [PORT_W-1:0] resultPort,
  output logic              resultNoMatch
);

  logic [PAT_W-1:0]  patTable  [ROWS];
  logic [PORT_W-1:0] portTable [ROWS];
  logic [ROWS-1:0]   rowValid;

  logic [ADDR_W-1:0] addrQ;
  logic [ROWS-1:0]   matchRaw;
  logic [ROWS-1:0]   matchQ;
  logic              anyHit;
  logic [IDX_W-1:0]  hitIdx;

  // Table write: one index addresses both the pattern and the port value.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rowValid <= '0;
      for (int r = 0; r < ROWS; r++) begin
        patTable[r]  <= '0;
        portTable[r] <= '0;
      end
    end else if (strobes.writeEn && (int'(progRow) < ROWS)) begin
      patTable[progRow]  <= progPattern;
      portTable[progRow] <= progPort;
      rowValid[progRow]  <= progRowValid;
    end
  end

  // Stage 1: address latch.
  always_ff @(posedge clk) begin
    if (!rst_n) addrQ <= '0;
    else if (strobes.latchEn) addrQ <= lookupAddr;
  end

  // Stage 2: ternary compare across all rows.
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [ADDR_W-1:0] digitOk;
    for (genvar d = 0; d < ADDR_W; d++) begin : g_digit
      assign digitOk[d] = (!patTable[r][2*d]   ||  addrQ[d]) &&
                          (!patTable[r][2*d+1] || !addrQ[d]);
    end
    assign matchRaw[r] = rowValid[r] && (&digitOk);
  end

  // The match vector is cleared when no compare runs, so selection restarts.
  always_ff @(posedge clk) begin
    if (!rst_n) matchQ <= '0;
    else if (strobes.cmpEn) matchQ <= matchRaw;
    else matchQ <= '0;
  end

  route_lookup_prio #(.ROWS(ROWS)) u_prio (
    .hits  (matchQ),
    .anyHit(anyHit),
    .hitIdx(hitIdx)
  );

  // Stage 3: select and port-table read.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resultPort    <= '0;
      resultNoMatch <= 1'b0;
    end else if (strobes.selEn) begin
      resultPort    <= anyHit ? portTable[hitIdx] : '0;
      resultNoMatch <= !anyHit;
    end else begin
      resultPort    <= '0;
      resultNoMatch <= 1'b0;
    end
  end

endmodule

// File: rtl/route_lookup.sv
module route_lookup
  import route_lookup_pkg::*;
#(
  parameter int ROWS   = 16,
  parameter int ADDR_W = 3,
  parameter int PORT_W = 2,
  localparam int IDX_W = $clog2(ROWS),
  localparam int PAT_W = 2 * ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lookupValid,
  input  logic [ADDR_W-1:0] lookupAddr,
  output logic              lookupStall,
  input  logic              progWrite,
  input  logic [IDX_W-1:0]  progRow,
  input  logic [PAT_W-1:0]  progPattern,
  input  logic [PORT_W-1:0] progPort,
  input  logic              progRowValid,
  output logic              progError,
  output logic              resultValid,
  output logic [PORT_W-1:0] resultPort,
  output logic              resultNoMatch
);

  ctrlStrobes_t strobes;

  route_lookup_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .lookupValid(lookupValid),
    .progWrite  (progWrite),
    .progPattern(progPattern),
    .strobes    (strobes),
    .lookupStall(lookupStall),
    .resultValid(resultValid),
    .progError  (progError)
  );

  route_lookup_datapath #(
    .ROWS  (ROWS),
    .ADDR_W(ADDR_W),
    .PORT_W(PORT_W)
  ) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobes      (strobes),
    .lookupAddr   (lookupAddr),
    .progRow      (progRow),
    .progPattern  (progPattern),
    .progPort     (progPort),
    .progRowValid (progRowValid),
    .resultPort   (resultPort),
    .resultNoMatch(resultNoMatch)
  );

endmodule

// File: rtl/route_lookup_chk.sv
module route_lookup_chk #(
  parameter int ROWS   = 16,
  parameter int ADDR_W = 3,
  parameter int PORT_W = 2,
  localparam int IDX_W = $clog2(ROWS),
  localparam int PAT_W = 2 * ADDR_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lookupValid,
  input logic              lookupStall,
  input logic              progWrite,
  input logic [PAT_W-1:0]  progPattern,
  input logic              progError,
  input logic              resultValid,
  input logic [PORT_W-1:0] resultPort,
  input logic              resultNoMatch
);

  logic       badPattern;
  logic       badWriteSeen;
  logic [2:0] acceptHist;

  always_comb begin
    badPattern = 1'b0;
    for (int d = 0; d < ADDR_W; d++) begin
      if (progPattern[2*d] && progPattern[2*d+1]) badPattern = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acceptHist   <= '0;
      badWriteSeen <= 1'b0;
    end else begin
      acceptHist   <= {acceptHist[1:0], lookupValid && !lookupStall};
      badWriteSeen <= progWrite && badPattern;
    end
  end

  // R7
  stall_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lookupStall == progWrite);

  // R2
  error_after_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    progError == badWriteSeen);

  // R6
  result_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resultValid == acceptHist[2]);

  // R9
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !resultValid |-> (resultPort == '0 && !resultNoMatch));

  // R4
  no_match_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resultNoMatch |-> (resultValid && resultPort == '0));

endmodule

bind route_lookup route_lookup_chk #(
  .ROWS  (ROWS),
  .ADDR_W(ADDR_W),
  .PORT_W(PORT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .lookupValid  (lookupValid),
  .lookupStall  (lookupStall),
  .progWrite    (progWrite),
  .progPattern  (progPattern),
  .progError    (progError),
  .resultValid  (resultValid),
  .resultPort   (resultPort),
  .resultNoMatch(resultNoMatch)
);

// File: tb/test_route_lookup.sv
module test_route_lookup;

  localparam int ROWS   = 16;
  localparam int ADDR_W = 3;
  localparam int PORT_W = 2;
  localparam int IDX_W  = 4;
  localparam int PAT_W  = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              lookupValid = 1'b0;
  logic [ADDR_W-1:0] lookupAddr = '0;
  logic              lookupStall;
  logic              progWrite = 1'b0;
  logic [IDX_W-1:0]  progRow = '0;
  logic [PAT_W-1:0]  progPattern = '0;
  logic [PORT_W-1:0] progPort = '0;
  logic              progRowValid = 1'b0;
  logic              progError;
  logic              resultValid;
  logic [PORT_W-1:0] resultPort;
  logic              resultNoMatch;

  int nChecks = 0;
  int nFail   = 0;

  always #2 clk = ~clk;

  route_lookup #(.ROWS(ROWS), .ADDR_W(ADDR_W), .PORT_W(PORT_W)) i_route_lookup (
    .clk(clk), .rst_n(rst_n),
    .lookupValid(lookupValid), .lookupAddr(lookupAddr), .lookupStall(lookupStall),
    .progWrite(progWrite), .progRow(progRow), .progPattern(progPattern),
    .progPort(progPort), .progRowValid(progRowValid), .progError(progError),
    .resultValid(resultValid), .resultPort(resultPort), .resultNoMatch(resultNoMatch)
  );

  // Reference state, advanced once per rising edge.
  logic [PAT_W-1:0]  shPat   [ROWS];
  logic [PORT_W-1:0] shPort  [ROWS];
  logic              shValid [ROWS];
  logic              m1V, m2V, m2Hit;
  logic [ADDR_W-1:0] m1Addr;
  int                m2Idx;
  logic              expV, expNoMatch, expErr;
  logic [PORT_W-1:0] expPort;

  function automatic bit patIllegal(logic [PAT_W-1:0] p);
    for (int d = 0; d < ADDR_W; d++) if (p[2*d +: 2] == 2'b11) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit patMatch(logic [PAT_W-1:0] p, logic [ADDR_W-1:0] a);
    for (int d = 0; d < ADDR_W; d++) begin
      if (p[2*d +: 2] == 2'b01 && !a[d]) return 1'b0;
      if (p[2*d +: 2] == 2'b10 &&  a[d]) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic modelReset();
    for (int r = 0; r < ROWS; r++) begin
      shPat[r] = '0; shPort[r] = '0; shValid[r] = 1'b0;
    end
    m1V = 0; m2V = 0; m2Hit = 0; m1Addr = '0; m2Idx = 0;
    expV = 0; expNoMatch = 0; expErr = 0; expPort = '0;
  endtask

  // Computes the state after the coming edge from the values before it.
  task automatic modelEdge();
    expV       = m2V;
    expNoMatch = m2V && !m2Hit;
    expPort    = (m2V && m2Hit) ? shPort[m2Idx] : '0;
    m2V   = m1V;
    m2Hit = 1'b0;
    m2Idx = 0;
    if (m1V) begin
      for (int r = 0; r < ROWS; r++) begin
        if (!m2Hit && shValid[r] && patMatch(shPat[r], m1Addr)) begin
          m2Hit = 1'b1; m2Idx = r;
        end
      end
    end
    m1V = lookupValid && !progWrite;
    if (m1V) m1Addr = lookupAddr;
    expErr = progWrite && patIllegal(progPattern);
    if (progWrite && !patIllegal(progPattern)) begin
      shPat[progRow]   = progPattern;
      shPort[progRow]  = progPort;
      shValid[progRow] = progRowValid;
    end
  endtask

  task automatic chk(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Called at a falling edge with inputs already driven.
  task automatic step(string req);
    chk("R7", "lookupStall", int'(lookupStall), int'(progWrite));
    modelEdge();
    @(posedge clk);
    @(negedge clk);
    chk(req, "resultValid", int'(resultValid), int'(expV));
    chk(req, "resultPort", int'(resultPort), int'(expPort));
    chk(req, "resultNoMatch", int'(resultNoMatch), int'(expNoMatch));
    chk(req, "progError", int'(progError), int'(expErr));
  endtask

  task automatic idle();
    lookupValid = 0; progWrite = 0;
  endtask

  task automatic doWrite(string req, int row, logic [PAT_W-1:0] pat, int port, bit vld);
    lookupValid = 0; progWrite = 1;
    progRow = IDX_W'(row); progPattern = pat; progPort = PORT_W'(port); progRowValid = vld;
    step(req);
    progWrite = 0;
  endtask

  task automatic doLookup(string req, int addr);
    progWrite = 0; lookupValid = 1; lookupAddr = ADDR_W'(addr);
    step(req);
    lookupValid = 0;
  endtask

  task automatic drain(string req);
    idle();
    for (int i = 0; i < 3; i++) step(req);
  endtask

  initial begin
    #(200000 * 4);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: outputs right after reset
    chk("R10", "resultValid", int'(resultValid), 0);
    chk("R10", "resultPort", int'(resultPort), 0);
    chk("R10", "resultNoMatch", int'(resultNoMatch), 0);
    chk("R10", "progError", int'(progError), 0);

    // R5: empty table yields no match
    doLookup("R5", 3);
    drain("R5");

    // R8: exact row for address 5 (digits 1,0,1 -> 01,10,01)
    doWrite("R8", 2, 6'b01_10_01, 3, 1'b1);
    doLookup("R8", 5);
    drain("R8");

    // R1: row 5 demands a one in digit 1 only
    doWrite("R1", 5, 6'b00_01_00, 1, 1'b1);
    doLookup("R1", 2);
    doLookup("R1", 5);
    doLookup("R1", 7);
    doLookup("R1", 6);
    drain("R1");

    // R4: address 0 hits nothing
    doLookup("R4", 0);
    doLookup("R4", 4);
    drain("R4");

    // R3: catch-all row 1 outranks rows 2 and 5
    doWrite("R3", 1, 6'b00_00_00, 2, 1'b1);
    for (int a = 0; a < 8; a++) doLookup("R3", a);
    drain("R3");

    // R5: row 1 made invalid stops matching
    doWrite("R5", 1, 6'b00_00_00, 0, 1'b0);
    doLookup("R5", 0);
    doLookup("R5", 7);
    drain("R5");

    // R2: illegal pattern refused, row 2 still maps address 5 to port 3
    doWrite("R2", 2, 6'b11_00_00, 0, 1'b0);
    step("R2");
    doLookup("R2", 5);
    drain("R2");

    // R7: write and lookup together; the lookup waits then enters
    lookupValid = 1; lookupAddr = 3'd2; progWrite = 1;
    progRow = 4'd9; progPattern = 6'b10_10_10; progPort = 2'd0; progRowValid = 1;
    step("R7");
    progWrite = 0;
    step("R7");
    drain("R7");

    // R6: back-to-back stream
    for (int a = 7; a >= 0; a--) doLookup("R6", a);
    drain("R6");

    // R9: idle outputs stay clear
    for (int i = 0; i < 4; i++) step("R9");

    // Random mix of writes and lookups
    for (int i = 0; i < 4000; i++) begin
      int sel;
      sel = int'($urandom_range(0, 99));
      lookupValid = (sel < 75);
      lookupAddr  = ADDR_W'($urandom);
      progWrite   = (sel % 5 == 0);
      progRow     = IDX_W'($urandom);
      progPattern = PAT_W'($urandom);
      progPort    = PORT_W'($urandom);
      progRowValid = ($urandom_range(0, 7) != 0);
      step("R6");
    end
    drain("R6");

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule